// File: doc/BRIEF.md
# Quad-Channel Parallel DAC Code Loader

This block is the parallel-bus front end of a four-channel, 14-bit digital-to-analog converter. A host writes codes over a 14-bit data bus, qualified by active-low chip-select and write strobes. A 3-bit channel address picks the destination input register. A mode input chooses between two ways of loading. A full-word write replaces all 14 bits at once. In byte mode, right-justified data goes in as an 8-bit low part and a 6-bit high part, and a byte-select input steers each write to one part.

Each channel has two stages: an input register and a DAC latch that drives the converter. A level-sensitive active-low load input moves the data on. If load stays high while writes arrive, only the input registers change, and a later low level on load updates every latch at the same time. If load is held low, each write appears in its channel's latch at the same clock edge that captures the write. An asynchronous active-low clear input forces all analog outputs to the sense-ground level and blocks the load input. The forced state stays after clear is released and ends only when load is next brought low.

The block runs on one system clock, and the bus strobes are sampled on that clock. Each strobe level must therefore last at least one clock period.

Top module: `quad_dac_par_loader`

## Requirements
- R1: After synchronous reset every DAC latch holds code 0 and `out_forced` is 1, which means the outputs are held at sense ground.
- R2: A write takes place when `wr_n` is seen rising, from 0 at one clock edge to 1 at the next, while `cs_n` is 0. Address, mode, byte select and data are taken at that second edge. With `word_mode`=1, all 14 bits of `data_in` replace the addressed input register.
- R3: With `word_mode`=0 and `byte_hi`=0, `data_in[7:0]` replaces code bits 7:0, and code bits 13:8 keep their old value.
- R4: With `word_mode`=0 and `byte_hi`=1, `data_in[5:0]` replaces code bits 13:8, and code bits 7:0 keep their old value.
- R5: A rising `wr_n` while `cs_n` is 1 changes no register.
- R6: Address values 0 to 3 select channels 0 to 3. Addresses 4 to 7 change no register. No write ever changes more than one channel.
- R7: While `load_n` is 1, no DAC latch changes.
- R8: At every clock edge where `load_n` is 0 and `clr_n` is 1, all four latches take the input-register contents, including a write captured at that same edge. A write made with `load_n` held low therefore appears on `dac_code` at the edge that captures it.
- R9: While `clr_n` is 0, `out_forced` is 1, and it becomes 1 without waiting for a clock edge. In that state `load_n` has no effect: writes change only the input registers.
- R10: Once `out_forced` is 1 and `clr_n` is 1, `out_forced` stays 1 until a clock edge samples `load_n` at 0. At that edge it clears.
- R11: Holding `wr_n` steady at either level, while `cs_n` is 0 and the data changes, performs no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; a write happens on its rising edge |
| addr | input | 3 | Channel address (0 to 3 valid) |
| word_mode | input | 1 | 1 = full 14-bit write, 0 = byte write |
| byte_hi | input | 1 | In byte mode: 1 = high 6-bit part, 0 = low 8-bit part |
| data_in | input | 14 | Right-justified write data |
| load_n | input | 1 | Level-sensitive active-low transfer to the DAC latches |
| clr_n | input | 1 | Asynchronous active-low force-to-sense-ground |
| dac_code | output | 56 | DAC latch codes, channel n at bits [14n+13:14n] |
| out_forced | output | 1 | 1 while the outputs are held at sense ground |

## Verification
The assertions check the clear and load rules on every cycle. They cover four points: clear forces the flag, the flag holds until load is seen low, the latches stay frozen while load is high or clear is low, and at most one channel takes a write. Which bits a byte write replaces, the strobe-edge qualification, and the masking of the upper addresses leave no trace that a single-cycle property can express. Only the bench's scenarios show them, by moving codes out through the load path and comparing them with values worked out by hand. The same holds for the rule that a write made under clear appears once the forced state ends.

// File: rtl/dql_pkg.sv
// Package: shared types of the parallel DAC loader.
// Assumes nothing beyond IEEE 1800-2017.
package dql_pkg;
    typedef enum logic {
        LOAD_BYTE = 1'b0,
        LOAD_WORD = 1'b1
    } load_mode_e;
endpackage

// File: rtl/dql_wr_detect.sv
// Write detector: finds the rising edge of the write strobe while chip select
// is low and decodes the channel address into one write enable per channel.
// Assumes each strobe level lasts at least one clock period.
module dql_wr_detect #(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_CH-1:0]   ch_we
);
    logic wr_q;
    logic strobe;

    // Remember the previous strobe level so a rising edge can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= 1'b1;
        else        wr_q <= wr_n;
    end

    // A write is qualified by a low-to-high strobe while chip select is low.
    always_comb strobe = wr_n && !wr_q && !cs_n;

    // One enable per channel; addresses at or above N_CH match no channel.
    for (genvar i = 0; i < N_CH; i++) begin : g_dec
        always_comb ch_we[i] = strobe && (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/dql_chan.sv
// One channel: an input register that takes full-word or byte writes, and a
// DAC latch that copies the next input-register value whenever xfer is high.
// Assumes CODE_W > LO_W.
module dql_chan
    import dql_pkg::*;
#(
    parameter int CODE_W = 14,
    parameter int LO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  load_mode_e        mode,
    input  logic              byte_hi,
    input  logic [CODE_W-1:0] data,
    input  logic              xfer,
    output logic [CODE_W-1:0] code
);
    localparam int HI_W = CODE_W - LO_W;

    logic [CODE_W-1:0] in_q;
    logic [CODE_W-1:0] in_next;

    // Merge the write into the input register according to mode and byte select.
    always_comb begin
        in_next = in_q;
        if (we) begin
            if (mode == LOAD_WORD)  in_next = data;
            else if (byte_hi)       in_next[CODE_W-1:LO_W] = data[HI_W-1:0];
            else                    in_next[LO_W-1:0] = data[LO_W-1:0];
        end
    end

    // Hold the input register and update the latch from the merged value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q <= '0;
            code <= '0;
        end else begin
            in_q <= in_next;
            if (xfer) code <= in_next;
        end
    end
endmodule

// File: rtl/dql_clr_ctl.sv
// Clear control: sets the forced-to-sense-ground flag at once when clear goes
// low, and releases it at the first clock edge with load low and clear high.
// Also produces the latch transfer enable, which clear blocks.
module dql_clr_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic load_n,
    output logic forced,
    output logic xfer
);
    // Asynchronous set by clear, synchronous set by reset, release by load.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)       forced <= 1'b1;
        else if (!rst_n)  forced <= 1'b1;
        else if (!load_n) forced <= 1'b0;
    end

    // The load level moves data only while clear is inactive.
    always_comb xfer = !load_n && clr_n;
endmodule

// File: rtl/quad_dac_par_loader.sv
// Top: parallel-bus loader for a four-channel DAC. It detects the writes,
// steers them into the per-channel input registers, and handles the load and
// clear control. Assumes bus strobes sampled on clk.
module quad_dac_par_loader
    import dql_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int CODE_W = 14,
    parameter int LO_W   = 8,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     wr_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     word_mode,
    input  logic                     byte_hi,
    input  logic [CODE_W-1:0]        data_in,
    input  logic                     load_n,
    input  logic                     clr_n,
    output logic [N_CH*CODE_W-1:0]   dac_code,
    output logic                     out_forced
);
    logic [N_CH-1:0] ch_we;
    logic            xfer;
    load_mode_e      mode;

    // Map the mode pin onto the load-mode type.
    always_comb mode = load_mode_e'(word_mode);

    dql_wr_detect #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
        .addr(addr), .ch_we(ch_we)
    );

    dql_clr_ctl u_clr (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
        .forced(out_forced), .xfer(xfer)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        dql_chan #(.CODE_W(CODE_W), .LO_W(LO_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .we(ch_we[i]), .mode(mode),
            .byte_hi(byte_hi), .data(data_in), .xfer(xfer),
            .code(dac_code[i*CODE_W +: CODE_W])
        );
    end
endmodule

// File: rtl/dql_chk.sv
// Checker for the loader: clear, load and write-enable rules on every cycle.
module dql_chk #(
    parameter int N_CH   = 4,
    parameter int CODE_W = 14
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   clr_n,
    input logic                   load_n,
    input logic                   out_forced,
    input logic [N_CH*CODE_W-1:0] dac_code,
    input logic [N_CH-1:0]        ch_we
);
    // R9
    clr_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> out_forced);

    // R10
    forced_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_forced && clr_n && load_n) |=> out_forced);

    // R10
    load_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !load_n) |=> (!out_forced || !clr_n));

    // R7
    latch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n || !clr_n) |=> $stable(dac_code));

    // R6
    single_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_we));
endmodule

bind quad_dac_par_loader dql_chk #(.N_CH(N_CH), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
    .out_forced(out_forced), .dac_code(dac_code), .ch_we(ch_we)
);

// File: tb/quad_dac_par_loader_tb.sv
module quad_dac_par_loader_tb;
    localparam int N_CH = 4;
    localparam int CW   = 14;

    typedef struct packed {
        logic        word;
        logic        hi;
        logic        cs;
        logic [2:0]  addr;
        logic [13:0] data;
        logic [1:0]  chk_ch;
        logic [13:0] exp;
        logic [3:0]  req;
    } vec_t;

    // Walked with load_n low: each write lands in the latch at once.
    localparam vec_t TABLE [11] = '{
        '{1'b1, 1'b0, 1'b0, 3'd0, 14'h1234, 2'd0, 14'h1234, 4'd2},  // R2
        '{1'b1, 1'b0, 1'b0, 3'd3, 14'h3FFF, 2'd3, 14'h3FFF, 4'd2},  // R2
        '{1'b0, 1'b0, 1'b0, 3'd1, 14'h00A5, 2'd1, 14'h00A5, 4'd3},  // R3
        '{1'b0, 1'b1, 1'b0, 3'd1, 14'h3F2A, 2'd1, 14'h2AA5, 4'd4},  // R4
        '{1'b0, 1'b0, 1'b0, 3'd1, 14'h3F11, 2'd1, 14'h2A11, 4'd3},  // R3
        '{1'b0, 1'b1, 1'b0, 3'd3, 14'h0000, 2'd3, 14'h00FF, 4'd4},  // R4
        '{1'b1, 1'b0, 1'b1, 3'd0, 14'h0555, 2'd0, 14'h1234, 4'd5},  // R5
        '{1'b1, 1'b0, 1'b0, 3'd4, 14'h0777, 2'd0, 14'h1234, 4'd6},  // R6
        '{1'b1, 1'b0, 1'b0, 3'd5, 14'h0777, 2'd1, 14'h2A11, 4'd6},  // R6
        '{1'b1, 1'b0, 1'b0, 3'd7, 14'h0777, 2'd3, 14'h00FF, 4'd6},  // R6
        '{1'b1, 1'b0, 1'b0, 3'd2, 14'h2001, 2'd2, 14'h2001, 4'd2}   // R2
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cs_n = 1'b1;
    logic                 wr_n = 1'b1;
    logic [2:0]           addr = '0;
    logic                 word_mode = 1'b1;
    logic                 byte_hi = 1'b0;
    logic [CW-1:0]        data_in = '0;
    logic                 load_n = 1'b1;
    logic                 clr_n = 1'b1;
    logic [N_CH*CW-1:0]   dac_code;
    logic                 out_forced;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    quad_dac_par_loader u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
        .word_mode(word_mode), .byte_hi(byte_hi), .data_in(data_in),
        .load_n(load_n), .clr_n(clr_n), .dac_code(dac_code),
        .out_forced(out_forced)
    );

    function automatic logic [CW-1:0] code_of(input int ch);
        return dac_code[ch*CW +: CW];
    endfunction

    task automatic check(input string req, input logic [CW-1:0] act,
                         input logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic wm, input logic hi, input logic cs,
                            input logic [2:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        word_mode = wm; byte_hi = hi; cs_n = cs; addr = a; data_in = d;
        wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int c = 0; c < N_CH; c++) check("R1", code_of(c), '0);
        check("R1", CW'(out_forced), CW'(1));

        // R10: forced holds with load high, releases on load low
        repeat (3) @(negedge clk);
        check("R10", CW'(out_forced), CW'(1));
        load_n = 1'b0;
        @(negedge clk);
        check("R10", CW'(out_forced), CW'(0));

        // Table walk (R2..R6)
        foreach (TABLE[i]) begin
            do_write(TABLE[i].word, TABLE[i].hi, TABLE[i].cs, TABLE[i].addr,
                     TABLE[i].data);
            check($sformatf("R%0d vector %0d", TABLE[i].req, i),
                  code_of(int'(TABLE[i].chk_ch)), TABLE[i].exp);
        end

        // R7: load high freezes latches; R8: load low moves all at once
        @(negedge clk);
        load_n = 1'b1;
        do_write(1'b1, 1'b0, 1'b0, 3'd2, 14'h0ABC);
        do_write(1'b0, 1'b0, 1'b0, 3'd0, 14'h0011);
        check("R7", code_of(2), 14'h2001);
        check("R7", code_of(0), 14'h1234);
        load_n = 1'b0;
        @(negedge clk);
        check("R8", code_of(2), 14'h0ABC);
        check("R8", code_of(0), 14'h1211);

        // R11: steady strobe levels do not write
        cs_n = 1'b0; word_mode = 1'b1; addr = 3'd0; data_in = 14'h3333;
        repeat (3) @(negedge clk);
        check("R11", code_of(0), 14'h1211);
        wr_n = 1'b0; data_in = 14'h2222;
        repeat (3) @(negedge clk);
        check("R11", code_of(0), 14'h1211);
        wr_n = 1'b1;
        @(negedge clk);
        check("R2", code_of(0), 14'h2222);
        cs_n = 1'b1;

        // R9: clear forces at once and blocks load
        #2 clr_n = 1'b0;
        #1 check("R9", CW'(out_forced), CW'(1));
        do_write(1'b1, 1'b0, 1'b0, 3'd3, 14'h0101);
        check("R9", code_of(3), 14'h00FF);
        check("R9", CW'(out_forced), CW'(1));

        // R10: release clear with load high, forced remains
        @(negedge clk);
        load_n = 1'b1;
        clr_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10", CW'(out_forced), CW'(1));
        check("R10", code_of(3), 14'h00FF);
        load_n = 1'b0;
        @(negedge clk);
        check("R10", CW'(out_forced), CW'(0));
        check("R8", code_of(3), 14'h0101);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule